// File: doc/BRIEF.md
# A/D Conversion Sequencing Controller

This block times one successive-approximation conversion for a small A/D peripheral. A prescaler derives an A/D clock enable from the system clock. A 3-bit select picks the divide ratio, a power of two from 1 to 128. The block does nothing while its enable input is low. After the enable rises, a settling interval counted in system clocks must run out before any start request is taken.

An accepted start raises the busy flag and latches the requested channel. The block then holds the sample switch closed for four A/D clocks. Over the next twelve A/D clocks it resolves the result one bit per A/D clock, most significant bit first. It drives a trial code to an external DAC and comparator. It reads back a single bit that says whether the input lies below the trial code. The result register loads only when the last bit is resolved. A conversion that is cut short keeps the previous result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With divide select N (0..7), one conversion keeps `busy` high for exactly 16·2^N system clock cycles.
- R2: `sample_hold` is high for the first 4·2^N cycles of a conversion, from the cycle in which `busy` rises, and low for the remaining 12·2^N.
- R3: A start request while `enable` is low is ignored and `busy` stays low.
- R4: After `enable` rises, a start held high is first accepted on the (SETTLE_CYC+1)-th rising clock edge that samples `enable` high. An earlier request is ignored.
- R5: A start request while `busy` is high is ignored. The running conversion keeps its length, channel and result, and no second conversion follows.
- R6: In the first conversion cycle the trial code is 0x800. Each bit is tried set and is cleared when `cmp_below`=1 (input below the trial code). With an ideal comparator the result equals the input code.
- R7: `result` changes only at the end of a completed conversion and holds during the following conversion.
- R8: Dropping `enable` during a conversion clears `busy`, `sample_hold` and `trial_code` one cycle later and leaves `result` unchanged.
- R9: `ch_out` takes `ch_sel` at the accepted start and holds it while `busy` is high. Back-to-back conversions may use different channels.
- R10: During reset `busy`, `sample_hold`, `trial_code` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Power/enable control; low aborts and powers down |
| div_sel | input | 3 | A/D clock select, divide by 2^div_sel |
| start | input | 1 | Conversion request |
| ch_sel | input | 4 | Requested input channel |
| cmp_below | input | 1 | Comparator: analog input is below the trial code |
| busy | output | 1 | Conversion in progress |
| sample_hold | output | 1 | Sample switch closed |
| ch_out | output | 4 | Latched channel for the multiplexer |
| trial_code | output | 12 | Trial code to the DAC, zero outside the bit phase |
| result | output | 12 | Last completed conversion result |

## Verification
The bench keeps the 12-bit resolution, 4-cycle sampling and 3-bit select defaults. It shortens SETTLE_CYC to 20, so the settling gate can be measured exactly both after power-up and after an abort. The table walks all eight divide ratios, so the longest conversion of 2048 cycles and the edge codes 0x000, 0xFFF, 0x800 and 0x7FF are all covered. An ideal comparator modelled in the bench makes the expected result equal to the applied code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_SAMPLE  = 2'd1,
      PH_CONVERT = 2'd2
   } phase_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int CNT_W = (1 << SEL_W) - 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("adc_clk_div: SEL_W must be 1..4");
      end
      for (genvar b = 0; b < CNT_W; b++) begin : g_mask
         assign mask[b] = (b < int'(sel));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   assign tick = run && ((cnt & mask) == mask);

   // R1
   undivided_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && sel == '0 && $past(sel) == '0) |-> tick);
endmodule

// File: rtl/adc_settle.sv
module adc_settle #(
   parameter int SETTLE_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   output logic ready
);
   generate
      if (SETTLE_CYC < 0) begin : g_bad
         $error("adc_settle: SETTLE_CYC must not be negative");
      end
      if (SETTLE_CYC == 0) begin : g_none
         assign ready = enable;
      end else begin : g_count
         localparam int CW = $clog2(SETTLE_CYC + 1);
         localparam logic [CW-1:0] LIM = CW'(SETTLE_CYC);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!enable)    cnt <= '0;
            else if (cnt != LIM) cnt <= cnt + 1'b1;
         end
         assign ready = enable && (cnt == LIM);
      end
   endgenerate
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
   import adc_seq_pkg::*;
#(
   parameter int RES_W      = 12,
   parameter int SAMPLE_CYC = 4,
   parameter int CH_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             go,
   input  logic             tick,
   input  logic [CH_W-1:0]  ch_in,
   input  logic             cmp_below,
   output logic             busy,
   output logic             sample_hold,
   output logic [CH_W-1:0]  ch_out,
   output logic [RES_W-1:0] trial,
   output logic             fin,
   output logic [RES_W-1:0] fin_code
);
   localparam int IDX_W  = $clog2(RES_W);
   localparam int SCNT_W = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
   localparam logic [RES_W-1:0]  MSB   = {1'b1, {(RES_W-1){1'b0}}};
   localparam logic [IDX_W-1:0]  TOP   = IDX_W'(RES_W - 1);
   localparam logic [SCNT_W-1:0] S_END = SCNT_W'(SAMPLE_CYC - 1);

   generate
      if (RES_W < 2)      begin : g_bad_res  $error("adc_sar_core: RES_W must be >= 2"); end
      if (SAMPLE_CYC < 1) begin : g_bad_samp $error("adc_sar_core: SAMPLE_CYC must be >= 1"); end
      if (CH_W < 1)       begin : g_bad_ch   $error("adc_sar_core: CH_W must be >= 1"); end
   endgenerate

   phase_t            phase;
   logic [SCNT_W-1:0] scnt;
   logic [IDX_W-1:0]  idx;
   logic [RES_W-1:0]  sar;
   logic [RES_W-1:0]  sar_nxt;
   logic [CH_W-1:0]   ch_q;

   always_comb begin
      sar_nxt = sar;
      if (cmp_below) sar_nxt[idx] = 1'b0;
      if (idx != '0) sar_nxt[idx - 1'b1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         scnt  <= '0;
         idx   <= '0;
         sar   <= '0;
         ch_q  <= '0;
      end else if (!enable) begin
         phase <= PH_IDLE;
      end else begin
         case (phase)
            PH_IDLE: if (go) begin
               phase <= PH_SAMPLE;
               scnt  <= '0;
               ch_q  <= ch_in;
            end
            PH_SAMPLE: if (tick) begin
               if (scnt == S_END) begin
                  phase <= PH_CONVERT;
                  sar   <= MSB;
                  idx   <= TOP;
               end else begin
                  scnt <= scnt + 1'b1;
               end
            end
            PH_CONVERT: if (tick) begin
               sar <= sar_nxt;
               if (idx == '0) phase <= PH_IDLE;
               else           idx   <= idx - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy        = (phase != PH_IDLE);
   assign sample_hold = (phase == PH_SAMPLE);
   assign trial       = (phase == PH_CONVERT) ? sar : '0;
   assign ch_out      = ch_q;
   assign fin         = enable && tick && (phase == PH_CONVERT) && (idx == '0);
   assign fin_code    = sar_nxt;

   // R2
   sample_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> sample_hold);
   // R6
   msb_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $fell(sample_hold)) |-> (trial == MSB));
   // R8
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !busy);
   // R9
   chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ch_out));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int RES_W      = 12,
   parameter int SAMPLE_CYC = 4,
   parameter int CH_W       = 4,
   parameter int SEL_W      = 3,
   parameter int SETTLE_CYC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             start,
   input  logic [CH_W-1:0]  ch_sel,
   input  logic             cmp_below,
   output logic             busy,
   output logic             sample_hold,
   output logic [CH_W-1:0]  ch_out,
   output logic [RES_W-1:0] trial_code,
   output logic [RES_W-1:0] result
);
   logic ready;
   logic tick;
   logic go;
   logic fin;
   logic [RES_W-1:0] fin_code;

   adc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ready(ready)
   );

   adc_clk_div #(.SEL_W(SEL_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .sel(div_sel), .tick(tick)
   );

   assign go = start && ready && !busy;

   adc_sar_core #(.RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC), .CH_W(CH_W)) u_core (
      .clk(clk), .rst_n(rst_n), .enable(enable), .go(go), .tick(tick),
      .ch_in(ch_sel), .cmp_below(cmp_below), .busy(busy),
      .sample_hold(sample_hold), .ch_out(ch_out), .trial(trial_code),
      .fin(fin), .fin_code(fin_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   result <= '0;
      else if (fin) result <= fin_code;
   end

   // R3
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(enable && ready));
   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fin) |-> $stable(result));
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
   localparam int SETTLE = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [2:0]  div_sel = '0;
   logic        start = 1'b0;
   logic [3:0]  ch_sel = '0;
   logic        cmp_below;
   logic        busy, sample_hold;
   logic [3:0]  ch_out;
   logic [11:0] trial_code, result;
   logic [11:0] vin = '0;
   logic [11:0] exp_res = '0;
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   assign cmp_below = (vin < trial_code);

   adc_seq_ctrl #(.SETTLE_CYC(SETTLE)) i_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
      .start(start), .ch_sel(ch_sel), .cmp_below(cmp_below), .busy(busy),
      .sample_hold(sample_hold), .ch_out(ch_out), .trial_code(trial_code),
      .result(result)
   );

   localparam logic [18:0] VECS [0:7] = '{
      {3'd0, 4'h1, 12'h000}, {3'd1, 4'h2, 12'hFFF},
      {3'd2, 4'h3, 12'h800}, {3'd3, 4'h0, 12'h7FF},
      {3'd4, 4'hF, 12'h001}, {3'd5, 4'h8, 12'hA5A},
      {3'd6, 4'h5, 12'h3FE}, {3'd7, 4'h9, 12'hC01}
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic conv(input logic [2:0] div, input logic [3:0] ch,
                       input logic [11:0] v, input bit mid);
      int n = 0, sh = 0, ft = -1, chbad = 0, resbad = 0;
      @(negedge clk);
      div_sel = div; ch_sel = ch; vin = v; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 busy rises after start", int'(busy), 1);
      while (busy && n < 5000) begin
         if (sample_hold) sh++;
         else if (ft < 0) ft = int'(trial_code);
         if (ch_out != ch) chbad++;
         if (result != exp_res) resbad++;
         if (mid && n == 5) begin start = 1'b1; ch_sel = ~ch; end
         if (mid && n == 6) start = 1'b0;
         n++;
         @(negedge clk);
      end
      chk("R1 busy length", n, 16 << div);
      chk("R2 sample length", sh, 4 << div);
      chk("R6 first trial code", ft, 12'h800);
      chk("R9 channel held", chbad, 0);
      chk("R7 result held during conversion", resbad, 0);
      chk("R6 result equals input", int'(result), int'(v));
      exp_res = v;
      if (mid) begin
         @(negedge clk);
         chk("R5 no second conversion", int'(busy), 0);
      end
   endtask

   task automatic settle_count(input string tag);
      int n = 0;
      @(negedge clk);
      enable = 1'b1; start = 1'b1;
      while (!busy && n < 1000) begin
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      chk(tag, n, SETTLE + 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset busy", int'(busy), 0);
      chk("R10 reset sample_hold", int'(sample_hold), 0);
      chk("R10 reset trial", int'(trial_code), 0);
      chk("R10 reset result", int'(result), 0);
      rst_n = 1'b1;

      // R3: start while disabled
      @(negedge clk); start = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R3 start ignored while disabled", int'(busy), 0);
      end
      start = 1'b0;

      // R4: settling gate after power-up
      vin = 12'h5A5; ch_sel = 4'h3; div_sel = 3'd0;
      settle_count("R4 settle gate after enable");
      for (int k = 0; k < 100 && busy; k++) @(negedge clk);
      chk("R6 result after settle conversion", int'(result), 12'h5A5);
      exp_res = 12'h5A5;

      // table of conversions, R1 R2 R6 R7 R9
      for (int i = 0; i < 8; i++)
         conv(VECS[i][18:16], VECS[i][15:12], VECS[i][11:0], 1'b0);

      // R5: start during busy with a different channel
      conv(3'd1, 4'hA, 12'h3C3, 1'b1);

      // R8: abort mid conversion
      @(negedge clk);
      div_sel = 3'd2; vin = 12'h999; ch_sel = 4'h6; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      chk("R8 busy before abort", int'(busy), 1);
      enable = 1'b0;
      @(negedge clk);
      chk("R8 busy cleared", int'(busy), 0);
      chk("R8 sample_hold cleared", int'(sample_hold), 0);
      chk("R8 trial cleared", int'(trial_code), 0);
      chk("R8 result unchanged", int'(result), int'(exp_res));

      // R4 again after re-enable
      settle_count("R4 settle gate after re-enable");
      for (int k = 0; k < 200 && busy; k++) @(negedge clk);
      chk("R6 result after re-enable", int'(result), 12'h999);
      exp_res = 12'h999;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule